// File: doc/BRIEF.md
# Interleaved Two-Port Bank Front End

This block sits in front of the data array of a banked cache. Two requesters can each present one access per cycle (read or write of one data word per line). The line number of each address picks one of several single-ported banks: the bank bits are the lowest bits above the line offset, so consecutive lines fall into consecutive banks. The upper address bits select the row inside that bank. When the two requests fall into different banks, both are accepted in the same cycle. When they fall into the same bank, only one is accepted. The other sees its ready low, keeps its request on the port, and is accepted in a following cycle.

Priority on a collision goes to port 0 by default. A port that was refused in the previous cycle wins the next collision, so neither side can be locked out. Each bank read takes one cycle. A read accepted at a clock edge appears on the response port of the same requester after the next edge, tagged with the number of the port that issued it. Because that latency is fixed, responses leave each port in request order. Writes are silent.

Top module: `ilv_bank_front`

## Requirements
- R1: While reset is held, and in the first cycle after it with no requests, both `rsp_valid` bits are 0.
- R2: Line number = address >> log2(LINE_BYTES). Bank = line number mod NUM_BANKS. Row = line number / NUM_BANKS. Offset bits below the line boundary are ignored, so two addresses that differ only there reach the same stored word.
- R3: When both ports are valid and their bank numbers differ, both `req_ready` bits are 1 in that cycle.
- R4: When both ports are valid with equal bank numbers and neither was refused in the previous cycle, `req_ready` is 1 for port 0 and 0 for port 1.
- R5: When a port was valid and not ready in the previous cycle and a same-bank collision occurs now, that port is ready and the other is not. A port that is not colliding is always ready.
- R6: A read accepted (valid and ready, `req_we`=0) in cycle t gives `rsp_valid`=1 on the same port in cycle t+1. `rsp_data` then equals the value of the latest write to that line accepted before cycle t.
- R7: Whenever `rsp_valid[p]` is 1, `rsp_id[p]` equals p.
- R8: An accepted write (`req_we`=1) produces `rsp_valid`=0 on that port in the next cycle. It is visible to reads accepted in later cycles.
- R9: Under uniformly random addresses, the fraction of cycles with two fresh valid requests that collide lies between 18% and 32%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Request valid, bit p for port p |
| req_ready | output | 2 | Request accepted this cycle, bit p for port p |
| req_we | input | 2 | 1 = write, 0 = read |
| req_addr | input | 2 x ADDR_W | Byte address per port |
| req_wdata | input | 2 x DATA_W | Write data per port |
| rsp_valid | output | 2 | Read data valid per port |
| rsp_id | output | 2 | Issuing port number of the returned data (1 bit per port) |
| rsp_data | output | 2 x DATA_W | Read data per port |

## Verification
The hardest situation to reach is the chain in which a refused request on port 1 meets a fresh same-bank request on port 0 in the very next cycle. That is the only case where port 0 loses. It also leaves port 0 holding, so the following cycle has to release it. Directed steps build that chain on purpose, placing three lines in one bank with the port 0 request changed exactly in the cycle after the refusal. Randomly drawn traffic of mixed reads and writes then repeats collisions naturally. It also measures the collision rate among fresh request pairs.

// File: rtl/ilv_bank_pkg.sv
package ilv_bank_pkg;
   localparam int NPORT = 2;
   typedef logic [0:0] port_id_t;
endpackage

// File: rtl/ilv_bank_decode.sv
module ilv_bank_decode #(
   parameter int ADDR_W = 12,
   parameter int OFF_W  = 4,
   parameter int BANK_W = 2,
   localparam int ROW_W = ADDR_W - OFF_W - BANK_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank,
   output logic [ROW_W-1:0]  row
);
   assign bank = addr[OFF_W +: BANK_W];
   assign row  = addr[ADDR_W-1 : OFF_W+BANK_W];

   generate
      if (OFF_W > 0) begin : g_off
         logic unused_offset;
         assign unused_offset = ^addr[OFF_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/ilv_bank_arb.sv
module ilv_bank_arb #(
   parameter int BANK_W = 2,
   parameter bit FAIR   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        valid,
   input  logic [BANK_W-1:0] bank_a,
   input  logic [BANK_W-1:0] bank_b,
   output logic [1:0]        ready
);
   logic clash;
   logic b_first;

   assign clash = valid[0] & valid[1] & (bank_a == bank_b);

   generate
      if (FAIR) begin : g_fair
         logic b_waited_q;
         always_ff @(posedge clk) begin
            if (!rst_n) b_waited_q <= 1'b0;
            else        b_waited_q <= valid[1] & ~ready[1];
         end
         assign b_first = b_waited_q;
      end else begin : g_fixed
         assign b_first = 1'b0;
      end
   endgenerate

   assign ready[0] = ~(clash &  b_first);
   assign ready[1] = ~(clash & ~b_first);
endmodule

// File: rtl/ilv_bank_ram.sv
module ilv_bank_ram #(
   parameter int DATA_W = 32,
   parameter int ROW_W  = 6,
   localparam int DEPTH = 1 << ROW_W
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [ROW_W-1:0]  row,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[row] <= wdata;
         rdata <= mem[row];
      end
   end
endmodule

// File: rtl/ilv_bank_front.sv
module ilv_bank_front #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int NUM_BANKS  = 4,
   parameter bit FAIR       = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             req_valid,
   output logic [1:0]             req_ready,
   input  logic [1:0]             req_we,
   input  logic [1:0][ADDR_W-1:0] req_addr,
   input  logic [1:0][DATA_W-1:0] req_wdata,
   output logic [1:0]             rsp_valid,
   output logic [1:0]             rsp_id,
   output logic [1:0][DATA_W-1:0] rsp_data
);
   import ilv_bank_pkg::*;

   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int BANK_W = $clog2(NUM_BANKS);
   localparam int ROW_W  = ADDR_W - OFF_W - BANK_W;

   generate
      if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line
         $error("LINE_BYTES must be a power of two");
      end
      if (ROW_W < 1 || ROW_W > 12) begin : g_bad_rows
         $error("ADDR_W leaves no row bits or too many");
      end
   endgenerate

   logic [NPORT-1:0][BANK_W-1:0] port_bank;
   logic [NPORT-1:0][ROW_W-1:0]  port_row;
   logic [NPORT-1:0]             grant;

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_dec
         ilv_bank_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W)) u_dec (
            .addr (req_addr[p]),
            .bank (port_bank[p]),
            .row  (port_row[p])
         );
      end
   endgenerate

   ilv_bank_arb #(.BANK_W(BANK_W), .FAIR(FAIR)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (req_valid),
      .bank_a (port_bank[0]),
      .bank_b (port_bank[1]),
      .ready  (req_ready)
   );

   assign grant = req_valid & req_ready;

   logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
   logic [NUM_BANKS-1:0]             bank_owner_q;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic hit_a, hit_b, en;
         port_id_t sel;
         assign hit_a = grant[0] & (port_bank[0] == BANK_W'(b));
         assign hit_b = grant[1] & (port_bank[1] == BANK_W'(b));
         assign en    = hit_a | hit_b;
         assign sel   = hit_b;

         ilv_bank_ram #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_ram (
            .clk   (clk),
            .en    (en),
            .we    (req_we[sel]),
            .row   (port_row[sel]),
            .wdata (req_wdata[sel]),
            .rdata (bank_rdata[b])
         );

         always_ff @(posedge clk) begin
            if (!rst_n)  bank_owner_q[b] <= 1'b0;
            else if (en) bank_owner_q[b] <= sel;
         end
      end
   endgenerate

   logic [NPORT-1:0]             rd_pend_q;
   logic [NPORT-1:0][BANK_W-1:0] rd_bank_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_pend_q <= '0;
         rd_bank_q <= '0;
      end else begin
         rd_pend_q <= grant & ~req_we;
         rd_bank_q <= port_bank;
      end
   end

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_rsp
         assign rsp_valid[p] = rd_pend_q[p];
         assign rsp_id[p]    = bank_owner_q[rd_bank_q[p]];
         assign rsp_data[p]  = bank_rdata[rd_bank_q[p]];
      end
   endgenerate
endmodule

// File: rtl/ilv_bank_front_chk.sv
module ilv_bank_front_chk #(
   parameter int BANK_W = 2,
   parameter bit FAIR   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        req_valid,
   input logic [1:0]        req_ready,
   input logic [1:0]        req_we,
   input logic [BANK_W-1:0] bank_a,
   input logic [BANK_W-1:0] bank_b,
   input logic [1:0]        rsp_valid,
   input logic [1:0]        rsp_id
);
   logic both, same;
   assign both = req_valid[0] & req_valid[1];
   assign same = (bank_a == bank_b);

   p_both_served_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (both && !same) |-> (req_ready == 2'b11));

   p_single_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (both && same) |-> ($countones(req_ready) == 1));

   generate
      if (FAIR) begin : g_fair
         p_refused_a_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[0] && !req_ready[0]) |=> req_ready[0]);
         p_refused_b_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[1] && !req_ready[1]) |=> req_ready[1]);
      end
   endgenerate

   p_read_reply_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[0] && req_ready[0] && !req_we[0]) |=> rsp_valid[0]);
   p_read_reply_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[1] && req_ready[1] && !req_we[1]) |=> rsp_valid[1]);

   p_reply_id_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[0] |-> (rsp_id[0] == 1'b0));
   p_reply_id_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[1] |-> (rsp_id[1] == 1'b1));

   p_write_silent_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[0] && req_ready[0] && req_we[0]) |=> !rsp_valid[0]);
   p_write_silent_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[1] && req_ready[1] && req_we[1]) |=> !rsp_valid[1]);
endmodule

bind ilv_bank_front ilv_bank_front_chk #(.BANK_W(BANK_W), .FAIR(FAIR)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_we    (req_we),
   .bank_a    (port_bank[0]),
   .bank_b    (port_bank[1]),
   .rsp_valid (rsp_valid),
   .rsp_id    (rsp_id)
);

// File: tb/ilv_bank_front_test.sv
module ilv_bank_front_test;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;
   localparam int LINE_BYTES = 16;
   localparam int NB = 4;
   localparam int OFF_W = 4;
   localparam int LINES = 1 << (ADDR_W - OFF_W);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] req_valid = '0, req_ready, req_we = '0;
   logic [1:0][ADDR_W-1:0] req_addr = '0;
   logic [1:0][DATA_W-1:0] req_wdata = '0;
   logic [1:0] rsp_valid, rsp_id;
   logic [1:0][DATA_W-1:0] rsp_data;

   ilv_bank_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES),
                    .NUM_BANKS(NB), .FAIR(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   logic [DATA_W-1:0] refm [LINES];

   logic [1:0] cur_v = '0, cur_we = '0, pend = '0, hold = '0;
   logic [1:0][ADDR_W-1:0] cur_a = '0;
   logic [1:0][DATA_W-1:0] cur_d = '0;
   logic [1:0] nxt_v = '0, nxt_we = '0;
   logic [1:0][ADDR_W-1:0] nxt_a = '0;
   logic [1:0][DATA_W-1:0] nxt_d = '0;
   logic [1:0] exp_v = '0, last_wr = '0;
   logic [1:0][DATA_W-1:0] exp_d = '0;
   string exp_tag [2] = '{"R6", "R6"};
   string rd_tag = "R6";
   bit measure = 0;
   int pairs = 0, clashes = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   function automatic int line_of(input logic [ADDR_W-1:0] a);
      return int'(a) / LINE_BYTES;
   endfunction

   function automatic int bank_of(input logic [ADDR_W-1:0] a);
      return line_of(a) % NB;
   endfunction

   function automatic logic [ADDR_W-1:0] mk(input int row, input int bank, input int off);
      return ADDR_W'(((row * NB) + bank) * LINE_BYTES + off);
   endfunction

   task automatic set_req(input int p, input bit v, input bit we,
                          input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      nxt_v[p] = v; nxt_we[p] = we; nxt_a[p] = a; nxt_d[p] = d;
   endtask

   task automatic step();
      bit fresh_pair, conf;
      logic [1:0] er;
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
         chk(rsp_valid[p] === exp_v[p], last_wr[p] ? "R8" : "R6", 64'(rsp_valid[p]), 64'(exp_v[p]));
         if (exp_v[p]) begin
            chk(rsp_data[p] === exp_d[p], exp_tag[p], 64'(rsp_data[p]), 64'(exp_d[p]));
            chk(rsp_id[p] === 1'(p), "R7", 64'(rsp_id[p]), 64'(p));
         end
      end
      fresh_pair = !pend[0] && !pend[1];
      for (int p = 0; p < 2; p++) begin
         if (!pend[p]) begin
            cur_v[p] = nxt_v[p]; cur_we[p] = nxt_we[p];
            cur_a[p] = nxt_a[p]; cur_d[p] = nxt_d[p];
         end
      end
      req_valid = cur_v; req_we = cur_we; req_addr = cur_a; req_wdata = cur_d;
      #1;
      conf = cur_v[0] && cur_v[1] && (bank_of(cur_a[0]) == bank_of(cur_a[1]));
      er[0] = !(conf && hold[1]);
      er[1] = !(conf && !hold[1]);
      chk(req_ready === er, conf ? ((hold != 2'b00) ? "R5" : "R4") : "R3",
          64'(req_ready), 64'(er));
      if (measure && fresh_pair && cur_v[0] && cur_v[1]) begin
         pairs++;
         if (conf) clashes++;
      end
      for (int p = 0; p < 2; p++) begin
         bit acc;
         acc = cur_v[p] && req_ready[p];
         exp_v[p] = acc && !cur_we[p];
         last_wr[p] = acc && cur_we[p];
         if (exp_v[p]) begin
            exp_d[p] = refm[line_of(cur_a[p])];
            exp_tag[p] = rd_tag;
         end
         pend[p] = cur_v[p] && !req_ready[p];
         hold[p] = pend[p];
      end
      for (int p = 0; p < 2; p++)
         if (last_wr[p]) refm[line_of(cur_a[p])] = cur_d[p];
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(rsp_valid === 2'b00, "R1", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid === 2'b00, "R1", 64'(rsp_valid), 64'd0);

      // fill every line; lines 2k and 2k+1 sit in different banks (R3, R8)
      for (int k = 0; k < LINES / 2; k++) begin
         set_req(0, 1, 1, ADDR_W'((2*k) * LINE_BYTES), DATA_W'($urandom));
         set_req(1, 1, 1, ADDR_W'((2*k+1) * LINE_BYTES), DATA_W'($urandom));
         step();
      end
      set_req(0, 0, 0, '0, '0); set_req(1, 0, 0, '0, '0);
      step();

      // R3: different banks, both reads in one cycle
      set_req(0, 1, 0, mk(3, 0, 0), '0);
      set_req(1, 1, 0, mk(7, 1, 4), '0);
      step();
      set_req(0, 0, 0, '0, '0); set_req(1, 0, 0, '0, '0);
      step();

      // R4 then R5: collision chain in bank 2
      set_req(0, 1, 0, mk(1, 2, 0), '0);
      set_req(1, 1, 0, mk(9, 2, 0), '0);
      step();
      chk(pend === 2'b10, "R4", 64'(pend), 64'h2);
      set_req(0, 1, 0, mk(14, 2, 8), '0);
      set_req(1, 0, 0, '0, '0);
      step();
      chk(pend === 2'b01, "R5", 64'(pend), 64'h1);
      set_req(0, 0, 0, '0, '0);
      step();
      chk(pend === 2'b00, "R5", 64'(pend), 64'h0);
      step();

      // R2: write at offset 0, read back the same line at offset 15 on the other port
      set_req(0, 1, 1, mk(5, 3, 0), 32'hA5C3_0F1E);
      step();
      set_req(0, 0, 0, '0, '0);
      rd_tag = "R2";
      set_req(1, 1, 0, mk(5, 3, 15), '0);
      step();
      set_req(1, 0, 0, '0, '0);
      step();
      rd_tag = "R6";
      chk(refm[line_of(mk(5, 3, 15))] === 32'hA5C3_0F1E, "R2",
          64'(refm[line_of(mk(5, 3, 15))]), 64'hA5C3_0F1E);

      // random mixed traffic (R3..R9)
      measure = 1;
      for (int i = 0; i < 3000; i++) begin
         for (int p = 0; p < 2; p++)
            set_req(p, ($urandom % 4) != 0, ($urandom % 3) == 0,
                    ADDR_W'($urandom), DATA_W'($urandom));
         step();
      end
      measure = 0;
      set_req(0, 0, 0, '0, '0); set_req(1, 0, 0, '0, '0);
      repeat (3) step();

      chk(pairs > 500 && clashes * 100 >= pairs * 18 && clashes * 100 <= pairs * 32,
          "R9", 64'(clashes * 100 / (pairs > 0 ? pairs : 1)), 64'd25);
      finish_run();
   end
endmodule